// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

The sequencer produces the chip-wide internal reset and decides which clock the system runs on once reset ends. It works entirely in the free-running self clock domain. A power-on indication resets it asynchronously. An active-low external reset pin is synchronized and then filtered, so that glitches are rejected. An oscillator activity line is sampled to recognise live oscillation.

After power-on the block runs a clock quality check. The check passes once enough consecutive oscillator edges arrive, each close enough to the previous one. If the check fails before its timeout, the block falls back to the self clock. Either way, the internal reset is then held for a fixed stretch count before release.

An accepted external reset skips the check when the oscillator is both selected and still active. Otherwise it repeats the check. A sticky power-on flag is set only by power-on, which lets software tell a cold start from a warm one. Software clears the flag by writing 1. The block has no data stream; every pin is a plain level or pulse.

Top module: `rcs_startup_seq`

## Requirements
- R1: While `por_i` is high and directly after its release, `sys_rst_o` is 1, `clk_sel_o` is 0 (self clock) and `por_flag_o` is 1.
- R2: The external pin passes a two-flop synchronizer, and a low level must persist for MIN_LOW consecutive synchronized cycles to be accepted; a low pulse of fewer cycles leaves `sys_rst_o` at 0, and a low of MIN_LOW or more cycles asserts it.
- R3: An accepted external reset while `clk_sel_o` is 1 and the oscillator is active skips the quality check: `clk_sel_o` stays 1 and `sys_rst_o` falls STRETCH_CYC to STRETCH_CYC+4 cycles after the pin returns high.
- R4: After power-on, once QC_EDGES consecutive oscillator rising edges have been seen, `clk_sel_o` becomes 1 (oscillator) and reset is released STRETCH_CYC cycles later.
- R5: If the quality check has not passed within QC_TIMEOUT cycles, `clk_sel_o` is 0 (self clock), and after a power-on `sys_rst_o` falls QC_TIMEOUT+STRETCH_CYC to QC_TIMEOUT+STRETCH_CYC+6 cycles after `por_i` falls.
- R6: A gap of MAX_GAP or more cycles without an oscillator rising edge restarts the edge count of the quality check.
- R7: An accepted external reset while the self clock is selected or the oscillator is inactive runs a full quality check, which starts after the pin returns high and ends as in R4 or R5.
- R8: `por_flag_o` is set only by `por_i`, is cleared by a one-cycle pulse on `flag_clr_i`, is not set by an external reset, and power-on wins over a simultaneous clear.
- R9: `sys_rst_o` is 1 throughout the check, fallback and stretch phases, and `clk_sel_o` does not change while reset is released, even if the oscillator stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running self clock; all sequencing is counted in its cycles |
| por_i | input | 1 | Power-on reset indication, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to clk_i |
| osc_i | input | 1 | Oscillator activity line, toggles while the oscillator runs |
| flag_clr_i | input | 1 | Write-one pulse that clears the power-on flag |
| sys_rst_o | output | 1 | Internal system reset, active high |
| clk_sel_o | output | 1 | Clock select: 1 oscillator, 0 self clock |
| por_flag_o | output | 1 | Sticky power-on flag |

## Verification
The bench builds the block with MIN_LOW 2, MAX_GAP 8, QC_EDGES 16, QC_TIMEOUT 300 and the default STRETCH_CYC of 192. These values keep every passing check, timeout and stretch within a few hundred cycles. That makes the release-time windows of both the oscillator path and the fallback path measurable after each reset.

A short quality-check count lets the bench interrupt the oscillator partway through a check. Restarting the oscillator then shows that the count starts again, because a retained count would release reset too early. The stretch length stays at its default, so the release windows show the 192-to-196-cycle hold directly.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    ST_POR_HOLD      = 3'd0,
    ST_CLK_CHECK     = 3'd1,
    ST_SELF_FALLBACK = 3'd2,
    ST_RST_STRETCH   = 3'd3,
    ST_RUN           = 3'd4
  } seq_state_e;

  localparam logic SEL_SELF = 1'b0;
  localparam logic SEL_OSC  = 1'b1;

endpackage

// File: rtl/rcs_rst_filter.sv
module rcs_rst_filter #(
  parameter int MIN_LOW = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic req_o
);

  localparam int CW = $clog2(MIN_LOW) + 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_LOW - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      sync_q  <= 2'b11;
      low_cnt <= '0;
      req_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_n_i};
      if (sync_q[1]) begin
        low_cnt <= '0;
        req_o   <= 1'b0;
      end else begin
        if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
        if (low_cnt >= CNT_TOP) req_o <= 1'b1;
      end
    end
  end

  // R2: an accepted request is preceded by a synchronized low level
  a_r2_req_needs_low: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(req_o) |-> !$past(sync_q[1]));

endmodule

// File: rtl/rcs_osc_monitor.sv
module rcs_osc_monitor #(
  parameter int MAX_GAP = 8
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic osc_i,
  output logic edge_o,
  output logic alive_o
);

  localparam int GW = $clog2(MAX_GAP + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(MAX_GAP);

  logic [2:0]    samp_q;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      samp_q  <= '0;
      gap_cnt <= GAP_TOP;
    end else begin
      samp_q <= {samp_q[1:0], osc_i};
      if (edge_o)                  gap_cnt <= '0;
      else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign edge_o  = samp_q[1] & ~samp_q[2];
  assign alive_o = (gap_cnt < GAP_TOP);

  // R6: an edge always revives the activity indication
  a_r6_edge_revives: assert property (@(posedge clk_i) disable iff (por_i)
    edge_o |=> alive_o);

endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
  import rcs_pkg::*;
#(
  parameter int QC_EDGES    = 4096,
  parameter int QC_TIMEOUT  = 50000,
  parameter int STRETCH_CYC = 192
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       rst_req_i,
  input  logic       osc_edge_i,
  input  logic       osc_alive_i,
  output seq_state_e state_o,
  output logic       clk_sel_o
);

  localparam int TW = $clog2(QC_TIMEOUT + 1);
  localparam int EW = $clog2(QC_EDGES + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(QC_TIMEOUT - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(QC_EDGES - 1);
  localparam logic [SW-1:0] STR_LAST  = SW'(STRETCH_CYC - 1);

  logic [TW-1:0] tmo_cnt;
  logic [EW-1:0] edge_cnt;
  logic [SW-1:0] str_cnt;
  logic          skip_ok;

  assign skip_ok = (clk_sel_o == SEL_OSC) && osc_alive_i;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state_o   <= ST_POR_HOLD;
      clk_sel_o <= SEL_SELF;
      tmo_cnt   <= '0;
      edge_cnt  <= '0;
      str_cnt   <= '0;
    end else if (rst_req_i) begin
      tmo_cnt  <= '0;
      edge_cnt <= '0;
      str_cnt  <= '0;
      if (skip_ok) begin
        state_o <= ST_RST_STRETCH;
      end else begin
        state_o   <= ST_CLK_CHECK;
        clk_sel_o <= SEL_SELF;
      end
    end else begin
      unique case (state_o)
        ST_POR_HOLD: begin
          state_o <= ST_CLK_CHECK;
        end
        ST_CLK_CHECK: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (osc_edge_i) edge_cnt <= osc_alive_i ? edge_cnt + 1'b1 : EW'(1);
          else if (!osc_alive_i) edge_cnt <= '0;
          if (osc_edge_i && osc_alive_i && edge_cnt == EDGE_LAST) begin
            clk_sel_o <= SEL_OSC;
            state_o   <= ST_RST_STRETCH;
            str_cnt   <= '0;
          end else if (tmo_cnt == TMO_LAST) begin
            state_o <= ST_SELF_FALLBACK;
          end
        end
        ST_SELF_FALLBACK: begin
          clk_sel_o <= SEL_SELF;
          str_cnt   <= '0;
          state_o   <= ST_RST_STRETCH;
        end
        ST_RST_STRETCH: begin
          if (str_cnt == STR_LAST) begin
            str_cnt <= '0;
            state_o <= ST_RUN;
          end else begin
            str_cnt <= str_cnt + 1'b1;
          end
        end
        ST_RUN: begin
          state_o <= ST_RUN;
        end
        default: state_o <= ST_POR_HOLD;
      endcase
    end
  end

  // R5: the fallback state always leads into the stretch on the self clock
  a_r5_fallback_self: assert property (@(posedge clk_i) disable iff (por_i)
    (state_o == ST_SELF_FALLBACK && !rst_req_i) |=>
      (clk_sel_o == SEL_SELF && state_o == ST_RST_STRETCH));

  // R4: the oscillator is selected only on an edge seen during the check
  a_r4_osc_after_edge: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(clk_sel_o) |-> ($past(state_o) == ST_CLK_CHECK && $past(osc_edge_i)));

  // R3: a held external reset parks in the stretch only with a live, selected oscillator
  a_r3_skip_needs_osc: assert property (@(posedge clk_i) disable iff (por_i)
    ($past(rst_req_i) && state_o == ST_RST_STRETCH) |->
      ($past(osc_alive_i) && $past(clk_sel_o) == SEL_OSC));

endmodule

// File: rtl/rcs_startup_seq.sv
module rcs_startup_seq
  import rcs_pkg::*;
#(
  parameter int MIN_LOW     = 2,
  parameter int MAX_GAP     = 8,
  parameter int QC_EDGES    = 4096,
  parameter int QC_TIMEOUT  = 50000,
  parameter int STRETCH_CYC = 192
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic ext_rst_n_i,
  input  logic osc_i,
  input  logic flag_clr_i,
  output logic sys_rst_o,
  output logic clk_sel_o,
  output logic por_flag_o
);

  logic       rst_req;
  logic       osc_edge;
  logic       osc_alive;
  seq_state_e state;

  rcs_rst_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .pin_n_i (ext_rst_n_i),
    .req_o   (rst_req)
  );

  rcs_osc_monitor #(.MAX_GAP(MAX_GAP)) u_osc_mon (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .osc_i   (osc_i),
    .edge_o  (osc_edge),
    .alive_o (osc_alive)
  );

  rcs_seq_fsm #(
    .QC_EDGES    (QC_EDGES),
    .QC_TIMEOUT  (QC_TIMEOUT),
    .STRETCH_CYC (STRETCH_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .rst_req_i   (rst_req),
    .osc_edge_i  (osc_edge),
    .osc_alive_i (osc_alive),
    .state_o     (state),
    .clk_sel_o   (clk_sel_o)
  );

  assign sys_rst_o = (state != ST_RUN);

  // Sticky flag: power-on is the asynchronous set and so beats a clear
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)           por_flag_o <= 1'b1;
    else if (flag_clr_i) por_flag_o <= 1'b0;
  end

  // R2: an accepted external request keeps the system in reset
  a_r2_req_holds_reset: assert property (@(posedge clk_i) disable iff (por_i)
    rst_req |=> sys_rst_o);

  // R8: nothing but power-on can set the flag
  a_r8_flag_no_set: assert property (@(posedge clk_i) disable iff (por_i)
    !$rose(por_flag_o));

  // R9: clock selection holds still while the system runs
  a_r9_sel_stable_run: assert property (@(posedge clk_i) disable iff (por_i)
    (!sys_rst_o && !$past(sys_rst_o)) |-> $stable(clk_sel_o));

endmodule

// File: tb/test_rcs_startup_seq.sv
module test_rcs_startup_seq;

  localparam int MIN_LOW = 2;
  localparam int MAX_GAP = 8;
  localparam int QC      = 16;
  localparam int TO      = 300;
  localparam int STR     = 192;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ext_n = 1'b1;
  logic osc = 1'b0;
  logic clr = 1'b0;
  logic sys_rst, clk_sel, por_flag;

  always #4 clk = ~clk;

  rcs_startup_seq #(
    .MIN_LOW(MIN_LOW), .MAX_GAP(MAX_GAP), .QC_EDGES(QC),
    .QC_TIMEOUT(TO), .STRETCH_CYC(STR)
  ) i_rcs_startup_seq (
    .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .osc_i(osc),
    .flag_clr_i(clr), .sys_rst_o(sys_rst), .clk_sel_o(clk_sel),
    .por_flag_o(por_flag)
  );

  typedef struct {
    int    start;
    int    lo;
    int    hi;
    logic  sel;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit osc_run = 1'b0;
  int osc_ph = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // oscillator model: period of four clock cycles while running
  always @(negedge clk) begin
    if (osc_run) begin
      osc_ph = osc_ph + 1;
      if (osc_ph % 2 == 0) osc = ~osc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // monitor: on every release of reset, pop and compare the expected item
  bit prev_rst = 1'b1;
  always @(negedge clk) begin
    if (prev_rst && !sys_rst) begin
      if (q.size() == 0) begin
        chk(1'b0, "unexpected release", cyc, -1);
      end else begin
        exp_t e;
        int d;
        e = q.pop_front();
        d = cyc - e.start;
        chk(d >= e.lo && d <= e.hi, {e.tag, " release delay"}, d, e.lo);
        chk(clk_sel == e.sel, {e.tag, " clock select"}, int'(clk_sel), int'(e.sel));
      end
    end
    prev_rst = sys_rst;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_release(input int lo, input int hi, input logic sel, input string tag);
    exp_t e;
    e.start = cyc; e.lo = lo; e.hi = hi; e.sel = sel; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(q.size() == 0, {tag, " release seen"}, q.size(), 0);
    cycles(4);
  endtask

  task automatic ext_pulse(input int low_cycles);
    ext_n = 1'b0;
    cycles(low_cycles);
    ext_n = 1'b1;
  endtask

  initial begin
    // R1: reset state
    osc_run = 1'b1;
    cycles(5);
    chk(sys_rst == 1'b1, "R1 reset asserted", int'(sys_rst), 1);
    chk(clk_sel == 1'b0, "R1 self clock", int'(clk_sel), 0);
    chk(por_flag == 1'b1, "R1 flag set", int'(por_flag), 1);

    // R4: power-on with a healthy oscillator passes the check
    expect_release(STR + QC*4 - 8, STR + QC*4 + 12, 1'b1, "R4");
    por = 1'b0;
    cycles(1);
    chk(sys_rst == 1'b1 && clk_sel == 1'b0, "R1 just after release", int'(sys_rst), 1);
    drain("R4");

    // R8: write-one clear
    clr = 1'b1; cycles(1); clr = 1'b0; cycles(1);
    chk(por_flag == 1'b0, "R8 cleared", int'(por_flag), 0);

    // R2: a one-cycle glitch is ignored
    begin
      int hi_seen = 0;
      ext_pulse(MIN_LOW - 1);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sys_rst) hi_seen++;
      end
      chk(hi_seen == 0, "R2 glitch ignored", hi_seen, 0);
    end

    // R2: exactly MIN_LOW cycles low is accepted; R3 skip path follows
    expect_release(STR, STR + 4, 1'b1, "R2");
    ext_n = 1'b0; cycles(MIN_LOW); ext_n = 1'b1;
    q[0].start = cyc;
    cycles(3);
    chk(sys_rst == 1'b1, "R2 min pulse accepted", int'(sys_rst), 1);
    drain("R2");

    // R3: longer external reset with the oscillator selected and running
    ext_n = 1'b0;
    cycles(6);
    chk(sys_rst == 1'b1, "R3 held in reset", int'(sys_rst), 1);
    ext_n = 1'b1;
    expect_release(STR, STR + 4, 1'b1, "R3");
    drain("R3");
    chk(por_flag == 1'b0, "R8 external reset leaves flag", int'(por_flag), 0);

    // R9: oscillator stops while running, selection holds
    osc_run = 1'b0;
    cycles(30);
    chk(clk_sel == 1'b1 && sys_rst == 1'b0, "R9 select stable in run", int'(clk_sel), 1);

    // R7: external reset with a dead oscillator runs the check and times out
    ext_n = 1'b0; cycles(4); ext_n = 1'b1;
    expect_release(TO + STR, TO + STR + 6, 1'b0, "R7 dead");
    drain("R7 dead");

    // R8 priority and R5 timeout on power-on with no oscillator
    clr = 1'b1;
    por = 1'b1;
    cycles(3);
    clr = 1'b0;
    cycles(1);
    expect_release(TO + STR, TO + STR + 6, 1'b0, "R5");
    por = 1'b0;
    cycles(2);
    chk(por_flag == 1'b1, "R8 set wins over clear", int'(por_flag), 1);
    cycles(100);
    chk(sys_rst == 1'b1, "R9 reset held during check", int'(sys_rst), 1);
    drain("R5");

    // R7: self clock selected, oscillator alive, check passes
    osc_run = 1'b1;
    cycles(20);
    ext_n = 1'b0; cycles(4); ext_n = 1'b1;
    expect_release(STR + QC*4 - 8, STR + QC*4 + 12, 1'b1, "R7 live");
    drain("R7 live");

    // R6: interrupted oscillator restarts the edge count
    por = 1'b1;
    cycles(3);
    por = 1'b0;
    cycles(40);
    osc_run = 1'b0;
    cycles(20);
    osc_run = 1'b1;
    expect_release(STR + QC*4 - 8, STR + QC*4 + 12, 1'b1, "R6");
    drain("R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule